// File: doc/BRIEF.md
# Switch Port Packet Routing Decision

This block sits behind the header decoder of one switch port and decides, for each incoming transaction packet, where it goes. From the packet's format and type codes it picks one of three routing styles: address, identifier or implicit. It then compares the packet's address or target identifier against the port's configuration: its own identifier, its own memory windows, the memory windows of each downstream port, and the secondary-to-subordinate bus range behind each downstream port. The result is one of five outcomes: consume here, forward to exactly one downstream port, forward upstream, copy to every downstream port, or reject as unsupported.

The decision is registered. It appears one clock after the header strobe, together with a one-hot (or all-ones, for a broadcast) downstream port mask and the outgoing type code. A type-1 configuration request that is forwarded to the port whose secondary bus is its target bus leaves as type 0. The number of downstream ports, the number of own memory windows and the address width are parameters.

Top module: `pkt_route_decide`

## Requirements
- R1: `dec_valid` is high in the cycle after a cycle with `hdr_valid` high, and low in the cycle after a cycle with `hdr_valid` low; each accepted header gives exactly one decision.
- R2: While `rst` is high, `dec_valid` is low and `dec_port_mask` is zero.
- R3: Types 5'b00000 and 5'b00001 (memory), 5'b00010 (IO) and 5'b01100, 5'b01101, 5'b01110 (atomic) are routed by address. An address inside any own window (base <= address <= limit) gives action 0 (consume), even if a downstream window also holds it.
- R4: An address-routed packet that misses the own windows but lies inside downstream window i gives action 1 (forward down) with only mask bit i set. When several windows hold it, the lowest index wins.
- R5: Types 5'b00100 and 5'b00101 (configuration) are routed by `hdr_target_id`, and types 5'b01010 and 5'b01011 (completion) by `hdr_requester_id`. When that 16-bit identifier equals `own_id`, the action is 0 (consume).
- R6: An identifier-routed packet whose bus number (identifier bits 15:8) lies within the secondary-to-subordinate range of downstream port i gives action 1 with only mask bit i set. The lowest matching index wins.
- R7: A type 5'b00101 request forwarded down to a port whose secondary bus equals the target bus leaves with `dec_type` 5'b00100. In every other case `dec_type` equals the input type.
- R8: An address- or identifier-routed packet matching nothing gives action 4 (unsupported) when `from_upstream` is 1, and action 2 (forward upstream) when it is 0.
- R9: Message types (type bits 4:3 = 2'b10) with a 4-DW header (fmt bit 0 = 1) route by type bits 2:0: 000 and 101 give action 2, 011 gives action 3 (broadcast) with every mask bit set, 100 gives action 0, 001 uses address routing, 010 uses identifier routing on `hdr_target_id`, and 110 and 111 give action 4.
- R10: A message type whose fmt bit 0 is 0 (3-DW header) gives action 4.
- R11: Any other type code, or any fmt with bit 2 set, gives action 4.
- R12: `dec_port_mask` is zero for actions 0, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header fields below are valid this cycle |
| hdr_fmt | input | 3 | Format code (bit 0: 4-DW header, bit 1: with data) |
| hdr_type | input | 5 | Type code |
| hdr_addr | input | ADDR_W | Request address, zero-extended for 3-DW headers |
| hdr_target_id | input | 16 | Target bus/device/function for configuration and identifier-routed messages |
| hdr_requester_id | input | 16 | Requester identifier, used to route completions |
| from_upstream | input | 1 | 1 when the packet arrived on the upstream side |
| own_id | input | 16 | This port's own bus/device/function |
| own_base | input | NUM_BAR x ADDR_W | Own memory window bases |
| own_limit | input | NUM_BAR x ADDR_W | Own memory window limits (inclusive) |
| dn_base | input | NUM_DN x ADDR_W | Downstream port window bases |
| dn_limit | input | NUM_DN x ADDR_W | Downstream port window limits (inclusive) |
| dn_sec_bus | input | NUM_DN x 8 | Secondary bus number of each downstream port |
| dn_sub_bus | input | NUM_DN x 8 | Subordinate bus number of each downstream port |
| dec_valid | output | 1 | Decision valid |
| dec_action | output | 3 | 0 consume, 1 forward down, 2 forward upstream, 3 broadcast, 4 unsupported |
| dec_port_mask | output | NUM_DN | Downstream port selection |
| dec_type | output | 5 | Outgoing type code (after any type-1 to type-0 rewrite) |

## Verification
Two routing functions can claim the same packet in one cycle. An address can sit in an own window and in a downstream window at once, and a bus number can sit in two overlapping downstream ranges, or a forwarded type-1 request can meet the secondary-bus equality that triggers the rewrite. The bench configures one downstream window over the own window, and two overlapping bus and address ranges. It then sends packets into the shared parts and expects the consume decision and the lowest-index port to win. It also sends type-1 requests to buses both equal to and inside a port's secondary bus, and judges the outgoing type in each case.

// File: rtl/route_pkg.sv
package route_pkg;

    localparam logic [4:0] TY_MEM_RW   = 5'b00000;
    localparam logic [4:0] TY_MEM_LK   = 5'b00001;
    localparam logic [4:0] TY_IO       = 5'b00010;
    localparam logic [4:0] TY_CFG0     = 5'b00100;
    localparam logic [4:0] TY_CFG1     = 5'b00101;
    localparam logic [4:0] TY_CPL      = 5'b01010;
    localparam logic [4:0] TY_CPL_LK   = 5'b01011;
    localparam logic [4:0] TY_ATOM_ADD = 5'b01100;
    localparam logic [4:0] TY_ATOM_SWP = 5'b01101;
    localparam logic [4:0] TY_ATOM_CAS = 5'b01110;

    localparam logic [2:0] MSG_TO_ROOT = 3'b000;
    localparam logic [2:0] MSG_BY_ADDR = 3'b001;
    localparam logic [2:0] MSG_BY_ID   = 3'b010;
    localparam logic [2:0] MSG_BCAST   = 3'b011;
    localparam logic [2:0] MSG_LOCAL   = 3'b100;
    localparam logic [2:0] MSG_GATHER  = 3'b101;

    typedef enum logic [2:0] {
        ACT_CONSUME = 3'd0,
        ACT_DOWN    = 3'd1,
        ACT_UP      = 3'd2,
        ACT_BCAST   = 3'd3,
        ACT_UNSUP   = 3'd4
    } route_act_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_ID,
        K_UP,
        K_BCAST,
        K_LOCAL,
        K_BAD
    } route_kind_e;

    typedef struct packed {
        route_kind_e kind;
        logic        use_req_id;
        logic        is_cfg1;
    } route_class_t;

    function automatic route_class_t classify(input logic [2:0] fmt,
                                              input logic [4:0] typ);
        route_class_t c;
        c.kind       = K_BAD;
        c.use_req_id = 1'b0;
        c.is_cfg1    = 1'b0;
        if (fmt[2]) begin
            c.kind = K_BAD;
        end else if (typ[4:3] == 2'b10) begin
            if (fmt[0]) begin
                case (typ[2:0])
                    MSG_TO_ROOT, MSG_GATHER: c.kind = K_UP;
                    MSG_BY_ADDR:             c.kind = K_ADDR;
                    MSG_BY_ID:               c.kind = K_ID;
                    MSG_BCAST:               c.kind = K_BCAST;
                    MSG_LOCAL:               c.kind = K_LOCAL;
                    default:                 c.kind = K_BAD;
                endcase
            end
        end else begin
            case (typ)
                TY_MEM_RW, TY_MEM_LK, TY_IO,
                TY_ATOM_ADD, TY_ATOM_SWP, TY_ATOM_CAS: c.kind = K_ADDR;
                TY_CFG0: c.kind = K_ID;
                TY_CFG1: begin
                    c.kind    = K_ID;
                    c.is_cfg1 = 1'b1;
                end
                TY_CPL, TY_CPL_LK: begin
                    c.kind       = K_ID;
                    c.use_req_id = 1'b1;
                end
                default: c.kind = K_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/route_classify.sv
module route_classify
    import route_pkg::*;
(
    input  logic [2:0]    fmt,
    input  logic [4:0]    typ,
    input  logic [15:0]   target_id,
    input  logic [15:0]   requester_id,
    output route_class_t  cls,
    output logic [15:0]   route_id
);
    always_comb begin
        cls      = classify(fmt, typ);
        route_id = cls.use_req_id ? requester_id : target_id;
    end
endmodule

// File: rtl/range_hit.sv
module range_hit #(
    parameter int N = 4,
    parameter int W = 64
) (
    input  logic [W-1:0]          key,
    input  logic [N-1:0][W-1:0]   lo,
    input  logic [N-1:0][W-1:0]   hi,
    output logic                  any_hit,
    output logic [N-1:0]          first_hit
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (key >= lo[g]) && (key <= hi[g]);
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        first_hit = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !found) begin
                first_hit[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    assign any_hit = |hit;
endmodule

// File: rtl/route_select.sv
module route_select
    import route_pkg::*;
#(
    parameter int NUM_DN = 4
) (
    input  route_class_t      cls,
    input  logic [4:0]        typ,
    input  logic              from_up,
    input  logic              own_win_hit,
    input  logic              dn_win_any,
    input  logic [NUM_DN-1:0] dn_win_first,
    input  logic              own_id_hit,
    input  logic              bus_any,
    input  logic [NUM_DN-1:0] bus_first,
    input  logic [NUM_DN-1:0] bus_is_sec,
    output route_act_e        act,
    output logic [NUM_DN-1:0] mask,
    output logic [4:0]        typ_out
);
    route_act_e miss_act;

    assign miss_act = from_up ? ACT_UNSUP : ACT_UP;

    always_comb begin
        act     = ACT_UNSUP;
        mask    = '0;
        typ_out = typ;
        case (cls.kind)
            K_ADDR: begin
                if (own_win_hit) begin
                    act = ACT_CONSUME;
                end else if (dn_win_any) begin
                    act  = ACT_DOWN;
                    mask = dn_win_first;
                end else begin
                    act = miss_act;
                end
            end
            K_ID: begin
                if (own_id_hit) begin
                    act = ACT_CONSUME;
                end else if (bus_any) begin
                    act  = ACT_DOWN;
                    mask = bus_first;
                    if (cls.is_cfg1 && |(bus_first & bus_is_sec)) begin
                        typ_out = TY_CFG0;
                    end
                end else begin
                    act = miss_act;
                end
            end
            K_UP:    act = ACT_UP;
            K_BCAST: begin
                act  = ACT_BCAST;
                mask = '1;
            end
            K_LOCAL: act = ACT_CONSUME;
            default: act = ACT_UNSUP;
        endcase
    end
endmodule

// File: rtl/pkt_route_decide.sv
module pkt_route_decide
    import route_pkg::*;
#(
    parameter int NUM_DN  = 4,
    parameter int NUM_BAR = 2,
    parameter int ADDR_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           hdr_valid,
    input  logic [2:0]                     hdr_fmt,
    input  logic [4:0]                     hdr_type,
    input  logic [ADDR_W-1:0]              hdr_addr,
    input  logic [15:0]                    hdr_target_id,
    input  logic [15:0]                    hdr_requester_id,
    input  logic                           from_upstream,
    input  logic [15:0]                    own_id,
    input  logic [NUM_BAR-1:0][ADDR_W-1:0] own_base,
    input  logic [NUM_BAR-1:0][ADDR_W-1:0] own_limit,
    input  logic [NUM_DN-1:0][ADDR_W-1:0]  dn_base,
    input  logic [NUM_DN-1:0][ADDR_W-1:0]  dn_limit,
    input  logic [NUM_DN-1:0][7:0]         dn_sec_bus,
    input  logic [NUM_DN-1:0][7:0]         dn_sub_bus,
    output logic                           dec_valid,
    output logic [2:0]                     dec_action,
    output logic [NUM_DN-1:0]              dec_port_mask,
    output logic [4:0]                     dec_type
);
    localparam int BUS_W = 8;

    route_class_t       cls;
    logic [15:0]        route_id;
    logic [BUS_W-1:0]   route_bus;
    logic               own_win_hit;
    logic [NUM_BAR-1:0] own_win_first;
    logic               dn_win_any;
    logic [NUM_DN-1:0]  dn_win_first;
    logic               bus_any;
    logic [NUM_DN-1:0]  bus_first;
    logic [NUM_DN-1:0]  bus_is_sec;
    logic               own_id_hit;
    route_act_e         act_c;
    logic [NUM_DN-1:0]  mask_c;
    logic [4:0]         typ_c;

    route_classify u_class (
        .fmt          (hdr_fmt),
        .typ          (hdr_type),
        .target_id    (hdr_target_id),
        .requester_id (hdr_requester_id),
        .cls          (cls),
        .route_id     (route_id)
    );

    assign route_bus  = route_id[15:8];
    assign own_id_hit = (route_id == own_id);

    range_hit #(.N(NUM_BAR), .W(ADDR_W)) u_own_win (
        .key       (hdr_addr),
        .lo        (own_base),
        .hi        (own_limit),
        .any_hit   (own_win_hit),
        .first_hit (own_win_first)
    );

    range_hit #(.N(NUM_DN), .W(ADDR_W)) u_dn_win (
        .key       (hdr_addr),
        .lo        (dn_base),
        .hi        (dn_limit),
        .any_hit   (dn_win_any),
        .first_hit (dn_win_first)
    );

    range_hit #(.N(NUM_DN), .W(BUS_W)) u_bus (
        .key       (route_bus),
        .lo        (dn_sec_bus),
        .hi        (dn_sub_bus),
        .any_hit   (bus_any),
        .first_hit (bus_first)
    );

    for (genvar g = 0; g < NUM_DN; g++) begin : g_sec
        assign bus_is_sec[g] = (route_bus == dn_sec_bus[g]);
    end

    route_select #(.NUM_DN(NUM_DN)) u_sel (
        .cls          (cls),
        .typ          (hdr_type),
        .from_up      (from_upstream),
        .own_win_hit  (own_win_hit),
        .dn_win_any   (dn_win_any),
        .dn_win_first (dn_win_first),
        .own_id_hit   (own_id_hit),
        .bus_any      (bus_any),
        .bus_first    (bus_first),
        .bus_is_sec   (bus_is_sec),
        .act          (act_c),
        .mask         (mask_c),
        .typ_out      (typ_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid     <= 1'b0;
            dec_action    <= ACT_CONSUME;
            dec_port_mask <= '0;
            dec_type      <= '0;
        end else begin
            dec_valid <= hdr_valid;
            if (hdr_valid) begin
                dec_action    <= act_c;
                dec_port_mask <= mask_c;
                dec_type      <= typ_c;
            end
        end
    end
endmodule

// File: rtl/route_decide_chk.sv
module route_decide_chk
    import route_pkg::*;
#(
    parameter int NUM_DN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hdr_valid,
    input logic [2:0]        hdr_fmt,
    input logic [4:0]        hdr_type,
    input logic              dec_valid,
    input logic [2:0]        dec_action,
    input logic [NUM_DN-1:0] dec_port_mask,
    input logic [4:0]        dec_type
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> dec_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !dec_valid);

    p_down_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_action == ACT_DOWN) |-> ($countones(dec_port_mask) == 1));

    p_mask_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && (dec_action == ACT_CONSUME || dec_action == ACT_UP ||
                       dec_action == ACT_UNSUP)) |-> (dec_port_mask == '0));

    p_bcast_all_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_action == ACT_BCAST) |-> (&dec_port_mask));

    p_type_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_type != TY_CFG1) |=> (dec_type == $past(hdr_type)));

    p_rewrite_down_r7: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_type == TY_CFG1) |=>
        ((dec_type == TY_CFG1) || (dec_type == TY_CFG0 && dec_action == ACT_DOWN)));

    p_msg_short_r10: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_type[4:3] == 2'b10 && !hdr_fmt[0]) |=> (dec_action == ACT_UNSUP));

    p_prefix_bad_r11: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_fmt[2]) |=> (dec_action == ACT_UNSUP));
endmodule

bind pkt_route_decide route_decide_chk #(.NUM_DN(NUM_DN)) u_route_chk (
    .clk           (clk),
    .rst           (rst),
    .hdr_valid     (hdr_valid),
    .hdr_fmt       (hdr_fmt),
    .hdr_type      (hdr_type),
    .dec_valid     (dec_valid),
    .dec_action    (dec_action),
    .dec_port_mask (dec_port_mask),
    .dec_type      (dec_type)
);

// File: tb/pkt_route_decide_bench.sv
`timescale 1ns/1ps
module pkt_route_decide_bench;
    localparam int NUM_DN  = 4;
    localparam int NUM_BAR = 2;
    localparam int ADDR_W  = 64;

    typedef struct {
        logic [2:0]        act;
        logic [NUM_DN-1:0] mask;
        logic [4:0]        typ;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hdr_valid = 1'b0;
    logic [2:0] hdr_fmt = '0;
    logic [4:0] hdr_type = '0;
    logic [ADDR_W-1:0] hdr_addr = '0;
    logic [15:0] hdr_target_id = '0;
    logic [15:0] hdr_requester_id = '0;
    logic from_upstream = 1'b1;
    logic [15:0] own_id;
    logic [NUM_BAR-1:0][ADDR_W-1:0] own_base, own_limit;
    logic [NUM_DN-1:0][ADDR_W-1:0] dn_base, dn_limit;
    logic [NUM_DN-1:0][7:0] dn_sec_bus, dn_sub_bus;
    logic dec_valid;
    logic [2:0] dec_action;
    logic [NUM_DN-1:0] dec_port_mask;
    logic [4:0] dec_type;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    pkt_route_decide #(.NUM_DN(NUM_DN), .NUM_BAR(NUM_BAR), .ADDR_W(ADDR_W)) u_pkt_route_decide (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_fmt(hdr_fmt), .hdr_type(hdr_type),
        .hdr_addr(hdr_addr), .hdr_target_id(hdr_target_id), .hdr_requester_id(hdr_requester_id),
        .from_upstream(from_upstream), .own_id(own_id), .own_base(own_base), .own_limit(own_limit),
        .dn_base(dn_base), .dn_limit(dn_limit), .dn_sec_bus(dn_sec_bus), .dn_sub_bus(dn_sub_bus),
        .dec_valid(dec_valid), .dec_action(dec_action), .dec_port_mask(dec_port_mask),
        .dec_type(dec_type)
    );

    task automatic send(input logic [2:0] fmt, input logic [4:0] typ, input logic [63:0] addr,
                        input logic [15:0] tid, input logic [15:0] rid, input logic up,
                        input logic [2:0] eact, input logic [NUM_DN-1:0] emask,
                        input logic [4:0] etyp, input string tag);
        exp_t e;
        @(negedge clk);
        hdr_valid = 1'b1; hdr_fmt = fmt; hdr_type = typ; hdr_addr = addr;
        hdr_target_id = tid; hdr_requester_id = rid; from_upstream = up;
        e.act = eact; e.mask = emask; e.typ = etyp; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hdr_valid = 1'b0;
        end
    endtask

    // Monitor: compares each decision with the oldest expected item (R1 framing).
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (dec_valid) begin
                    exp_t e;
                    checks++;
                    if (q.size() == 0) begin
                        fails++;
                        $display("FAIL R1 unexpected decision: got valid=1 expected valid=0");
                    end else begin
                        e = q.pop_front();
                        if (dec_action !== e.act || dec_port_mask !== e.mask || dec_type !== e.typ) begin
                            fails++;
                            $display("FAIL %s: got act=%0d mask=%b type=%b expected act=%0d mask=%b type=%b",
                                     e.tag, dec_action, dec_port_mask, dec_type, e.act, e.mask, e.typ);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        own_id = 16'h0100;
        own_base[0] = 64'h1000_0000; own_limit[0] = 64'h1000_FFFF;
        own_base[1] = 64'h2000_0000; own_limit[1] = 64'h1000_0000;
        dn_base[0] = 64'h8000_0000; dn_limit[0] = 64'h8FFF_FFFF;
        dn_base[1] = 64'h9000_0000; dn_limit[1] = 64'h9FFF_FFFF;
        dn_base[2] = 64'h9800_0000; dn_limit[2] = 64'h98FF_FFFF;
        dn_base[3] = 64'h1000_0000; dn_limit[3] = 64'h1FFF_FFFF;
        dn_sec_bus[0] = 8'd2; dn_sub_bus[0] = 8'd3;
        dn_sec_bus[1] = 8'd4; dn_sub_bus[1] = 8'd7;
        dn_sec_bus[2] = 8'd5; dn_sub_bus[2] = 8'd6;
        dn_sec_bus[3] = 8'd9; dn_sub_bus[3] = 8'd8;

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0 || dec_port_mask !== '0) begin
            fails++;
            $display("FAIL R2 reset: got valid=%b mask=%b expected valid=0 mask=0000", dec_valid, dec_port_mask);
        end
        rst = 1'b0;
        idle(2);

        // R3: own window beats overlapping downstream window 3
        send(3'b000, 5'b00000, 64'h1000_0010, 16'h0, 16'h0, 1, 3'd0, 4'b0000, 5'b00000, "R3 own window");
        // R4: downstream windows, overlap lowest index
        send(3'b010, 5'b00000, 64'h8000_0040, 16'h0, 16'h0, 1, 3'd1, 4'b0001, 5'b00000, "R4 window0");
        send(3'b000, 5'b00010, 64'h9800_0000, 16'h0, 16'h0, 1, 3'd1, 4'b0010, 5'b00010, "R4 overlap low index");
        send(3'b011, 5'b01101, 64'h1800_0000, 16'h0, 16'h0, 1, 3'd1, 4'b1000, 5'b01101, "R4 atomic window3");
        idle(1);
        // R8: address miss by direction
        send(3'b001, 5'b00000, 64'h1_0000_0000, 16'h0, 16'h0, 1, 3'd4, 4'b0000, 5'b00000, "R8 addr miss from up");
        send(3'b001, 5'b00000, 64'h1_0000_0000, 16'h0, 16'h0, 0, 3'd2, 4'b0000, 5'b00000, "R8 addr miss from down");
        // R5, R6, R7: configuration
        send(3'b000, 5'b00100, 64'h0, 16'h0100, 16'h0, 1, 3'd0, 4'b0000, 5'b00100, "R5 cfg own id");
        send(3'b000, 5'b00101, 64'h0, 16'h0400, 16'h0, 1, 3'd1, 4'b0010, 5'b00100, "R7 cfg1 rewrite at secondary");
        send(3'b000, 5'b00101, 64'h0, 16'h0508, 16'h0, 1, 3'd1, 4'b0010, 5'b00101, "R6 R7 overlap no rewrite");
        send(3'b000, 5'b00101, 64'h0, 16'h0300, 16'h0, 1, 3'd1, 4'b0001, 5'b00101, "R6 cfg1 inside range");
        idle(2);
        // R5: completions use requester id field
        send(3'b010, 5'b01010, 64'h0, 16'h0100, 16'h0200, 1, 3'd1, 4'b0001, 5'b01010, "R5 cpl uses requester id");
        send(3'b000, 5'b01010, 64'h0, 16'h0700, 16'h0100, 1, 3'd0, 4'b0000, 5'b01010, "R5 cpl own id");
        send(3'b000, 5'b01011, 64'h0, 16'h0, 16'h2000, 1, 3'd4, 4'b0000, 5'b01011, "R8 id miss from up");
        send(3'b000, 5'b01011, 64'h0, 16'h0, 16'h2000, 0, 3'd2, 4'b0000, 5'b01011, "R8 id miss from down");
        // R9: messages
        send(3'b001, 5'b10000, 64'h0, 16'h0, 16'h0, 0, 3'd2, 4'b0000, 5'b10000, "R9 to root");
        send(3'b001, 5'b10101, 64'h0, 16'h0, 16'h0, 0, 3'd2, 4'b0000, 5'b10101, "R9 gather");
        send(3'b011, 5'b10011, 64'h0, 16'h0, 16'h0, 1, 3'd3, 4'b1111, 5'b10011, "R9 broadcast");
        send(3'b001, 5'b10100, 64'h0, 16'h0, 16'h0, 1, 3'd0, 4'b0000, 5'b10100, "R9 local");
        send(3'b001, 5'b10001, 64'h8000_0000, 16'h0, 16'h0, 1, 3'd1, 4'b0001, 5'b10001, "R9 by address");
        send(3'b001, 5'b10010, 64'h0, 16'h0700, 16'h0300, 1, 3'd1, 4'b0010, 5'b10010, "R9 by id");
        send(3'b001, 5'b10110, 64'h0, 16'h0, 16'h0, 1, 3'd4, 4'b0000, 5'b10110, "R9 reserved route");
        // R10, R11, R12
        send(3'b000, 5'b10011, 64'h0, 16'h0, 16'h0, 1, 3'd4, 4'b0000, 5'b10011, "R10 short message header");
        send(3'b000, 5'b11111, 64'h0, 16'h0, 16'h0, 1, 3'd4, 4'b0000, 5'b11111, "R11 unknown type");
        send(3'b100, 5'b00000, 64'h8000_0000, 16'h0, 16'h0, 1, 3'd4, 4'b0000, 5'b00000, "R11 prefix fmt R12");
        idle(4);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing decisions: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule